// File: doc/BRIEF.md
# Hamming(7,4) Single-Error-Correcting Codec

This block pairs a combinational encoder with a one-cycle registered decoder for a seven-bit code that protects a four-bit nibble. The encoder places the four data bits at the non-power-of-two positions of the codeword. It fills positions 1, 2 and 4 with even-parity check bits, so any single flipped bit of a stored or sent word can be found and repaired.

The decoder takes a received word together with a valid strobe and recomputes the three checks. The check results, read as a binary number, give the 1-indexed position of the bit that flipped. That bit is inverted, the data bits are gathered, and the repaired nibble is registered together with the syndrome and a correction flag. Two flipped bits are not detected. Such a word is decoded as though a single other bit had flipped, and this is the intended behaviour. The number of check bits is a parameter (default 3), and the other widths follow from it.

Top module: `hm74_codec`

## Requirements
- R1: Codeword bit k-1 holds position k (1..7). Data bit `enc_data[0]` (d1) sits at position 3, `[1]` at position 5, `[2]` at position 6 and `[3]` at position 7. Positions 1, 2 and 4 hold check bits.
- R2: The check bit at position 1 gives even parity over positions {1,3,5,7}. The one at position 2 gives even parity over {2,3,6,7}, and the one at position 4 gives even parity over {4,5,6,7}. The encoder output follows `enc_data` with no clock.
- R3: Encoding d1..d4 = 1,0,1,1 (`enc_data` = 4'b1101) yields positions 1..7 = 0,1,1,0,0,1,1 (`enc_code` = 7'b1100110). That word with position 5 inverted decodes to 4'b1101 with syndrome 5.
- R4: The syndrome is 4·c4 + 2·c2 + c1, where each c is the XOR of the received bits in that check's set. Any valid codeword gives syndrome 0 and returns its own data.
- R5: A received word with one inverted data position decodes to the original data, and the syndrome equals that position.
- R6: A received word with one inverted check position (1, 2 or 4) returns the received data bits unchanged, and the syndrome equals that position.
- R7: `out_valid` rises in the cycle after each cycle in which `in_valid` is high. Back-to-back inputs give back-to-back results.
- R8: In a cycle after one where `in_valid` is low, `out_valid` is low. `data_out`, `syndrome` and `err_corrected` keep their values, whatever `rx_code` carries.
- R9: `err_corrected` is high exactly when the registered syndrome is non-zero.
- R10: A synchronous active-high `rst` clears `out_valid`, `data_out`, `syndrome` and `err_corrected` to 0.
- R11: A word with two inverted positions a and b produces syndrome a XOR b. The decoder inverts that position if it is non-zero and returns the resulting data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_data | input | 4 | Nibble to encode |
| enc_code | output | 7 | Encoded word, bit k-1 = position k |
| in_valid | input | 1 | Strobe for `rx_code` |
| rx_code | input | 7 | Received word, bit k-1 = position k |
| out_valid | output | 1 | Decoded result valid |
| data_out | output | 4 | Corrected nibble |
| syndrome | output | 3 | Position found in error, 0 if none |
| err_corrected | output | 1 | A bit was inverted |

## Verification
The encoder and the decoder run in the same cycle without sharing state. Every decode word is therefore sent while the encoder is driven with an unrelated nibble. The bench compares the combinational codeword in that cycle, and the registered decode result one cycle later, with separate reference models. Some words loop the encoder output straight into the decoder, so both halves must agree in one pass. A run of back-to-back strobes with corrupted words, followed by idle cycles with noise on `rx_code`, checks that a new result and a held result never mix.

// File: rtl/hm_pkg.sv
package hm_pkg;

   function automatic bit is_pow2(int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // 1-indexed codeword position of data bit k (k-th non power-of-two slot)
   function automatic int data_pos(int r, int k);
      int cnt;
      cnt = 0;
      for (int p = 1; p < (1 << r); p++) begin
         if (!is_pow2(p)) begin
            if (cnt == k) return p;
            cnt++;
         end
      end
      return 0;
   endfunction

   // positions whose index has bit j set; bit p-1 stands for position p
   function automatic logic [63:0] cover_mask(int r, int j);
      logic [63:0] m;
      m = '0;
      for (int p = 1; p < (1 << r); p++)
         if (((p >> j) & 1) == 1) m[p-1] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/hm_enc.sv
module hm_enc #(
   parameter int PAR_W = 3,
   localparam int CW = (1 << PAR_W) - 1,
   localparam int DW = CW - PAR_W
) (
   input  logic [DW-1:0] data_i,
   output logic [CW-1:0] code_o
);
   logic [CW-1:0] placed;

   for (genvar p = 1; p <= CW; p++) begin : g_pos
      if (hm_pkg::is_pow2(p)) begin : g_chk
         assign placed[p-1] = 1'b0;
      end else begin : g_dat
         for (genvar k = 0; k < DW; k++) begin : g_k
            if (hm_pkg::data_pos(PAR_W, k) == p) begin : g_hit
               assign placed[p-1] = data_i[k];
            end
         end
      end
   end

   for (genvar p = 1; p <= CW; p++) begin : g_out
      if (hm_pkg::is_pow2(p)) begin : g_par
         localparam int J = $clog2(p);
         localparam logic [63:0] MASK = hm_pkg::cover_mask(PAR_W, J);
         assign code_o[p-1] = ^(placed & MASK[CW-1:0]);
      end else begin : g_pass
         assign code_o[p-1] = placed[p-1];
      end
   end
endmodule

// File: rtl/hm_syn.sv
module hm_syn #(
   parameter int PAR_W = 3,
   localparam int CW = (1 << PAR_W) - 1
) (
   input  logic [CW-1:0]    code_i,
   output logic [PAR_W-1:0] syn_o
);
   for (genvar j = 0; j < PAR_W; j++) begin : g_chk
      localparam logic [63:0] MASK = hm_pkg::cover_mask(PAR_W, j);
      assign syn_o[j] = ^(code_i & MASK[CW-1:0]);
   end
endmodule

// File: rtl/hm_dec.sv
module hm_dec #(
   parameter int PAR_W = 3,
   localparam int CW = (1 << PAR_W) - 1,
   localparam int DW = CW - PAR_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [CW-1:0]    rx_code,
   output logic             out_valid,
   output logic [DW-1:0]    data_out,
   output logic [PAR_W-1:0] syndrome,
   output logic             err_corrected
);
   logic [PAR_W-1:0] syn_w;
   logic [CW-1:0]    fixed;
   logic [DW-1:0]    data_fix;
   logic [DW-1:0]    data_raw;

   hm_syn #(.PAR_W(PAR_W)) u_syn (.code_i(rx_code), .syn_o(syn_w));

   // syndrome read directly as the 1-indexed position to invert
   for (genvar p = 1; p <= CW; p++) begin : g_fix
      assign fixed[p-1] = rx_code[p-1] ^ (syn_w == PAR_W'(p));
   end

   for (genvar k = 0; k < DW; k++) begin : g_ext
      localparam int P = hm_pkg::data_pos(PAR_W, k);
      assign data_fix[k] = fixed[P-1];
      assign data_raw[k] = rx_code[P-1];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid     <= 1'b0;
         data_out      <= '0;
         syndrome      <= '0;
         err_corrected <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            data_out      <= data_fix;
            syndrome      <= syn_w;
            err_corrected <= (syn_w != '0);
         end
      end
   end

   p_valid_next_r7: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid && $stable(data_out) && $stable(syndrome)
                    && $stable(err_corrected));

   p_flag_match_r9: assert property (@(posedge clk) disable iff (rst)
      err_corrected == (syndrome != '0));

   p_parity_hit_r6: assert property (@(posedge clk) disable iff (rst)
      in_valid && ($countones(syn_w) == 1) |=> data_out == $past(data_raw));
endmodule

// File: rtl/hm74_codec.sv
module hm74_codec #(
   parameter int PAR_W = 3,
   localparam int CW = (1 << PAR_W) - 1,
   localparam int DW = CW - PAR_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DW-1:0]    enc_data,
   output logic [CW-1:0]    enc_code,
   input  logic             in_valid,
   input  logic [CW-1:0]    rx_code,
   output logic             out_valid,
   output logic [DW-1:0]    data_out,
   output logic [PAR_W-1:0] syndrome,
   output logic             err_corrected
);
   if (PAR_W < 2 || PAR_W > 6) begin : g_bad_par
      $error("hm74_codec: PAR_W must lie in 2..6");
   end

   hm_enc #(.PAR_W(PAR_W)) u_enc (.data_i(enc_data), .code_o(enc_code));

   hm_dec #(.PAR_W(PAR_W)) u_dec (
      .clk(clk), .rst(rst), .in_valid(in_valid), .rx_code(rx_code),
      .out_valid(out_valid), .data_out(data_out), .syndrome(syndrome),
      .err_corrected(err_corrected)
   );

   p_loopback_clean_r4: assert property (@(posedge clk) disable iff (rst)
      in_valid && (rx_code == enc_code) |=>
         (syndrome == '0) && (data_out == $past(enc_data)));
endmodule

// File: tb/hm74_codec_tb.sv
`timescale 1ns/1ps
module hm74_codec_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] enc_data = '0;
   logic [6:0] enc_code;
   logic       in_valid = 1'b0;
   logic [6:0] rx_code = '0;
   logic       out_valid;
   logic [3:0] data_out;
   logic [2:0] syndrome;
   logic       err_corrected;

   always #2.5 clk = ~clk;

   hm74_codec u_dut (
      .clk(clk), .rst(rst), .enc_data(enc_data), .enc_code(enc_code),
      .in_valid(in_valid), .rx_code(rx_code), .out_valid(out_valid),
      .data_out(data_out), .syndrome(syndrome), .err_corrected(err_corrected)
   );

   typedef struct {
      logic [3:0] data;
      logic [2:0] syn;
      int         due;
      string      req;
   } item_t;

   item_t q[$];
   int    cyc = 0;
   int    n_run = 0;
   int    n_fail = 0;
   bit    done = 0;
   bit    have_last = 0;
   logic [3:0] last_d;
   logic [2:0] last_s;
   logic       last_e;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [6:0] ref_enc(logic [3:0] d);
      logic [6:0] c;
      c[2] = d[0]; c[4] = d[1]; c[5] = d[2]; c[6] = d[3];
      c[0] = c[2] ^ c[4] ^ c[6];
      c[1] = c[2] ^ c[5] ^ c[6];
      c[3] = c[4] ^ c[5] ^ c[6];
      return c;
   endfunction

   function automatic logic [2:0] ref_syn(logic [6:0] c);
      logic s1, s2, s4;
      s1 = c[0] ^ c[2] ^ c[4] ^ c[6];
      s2 = c[1] ^ c[2] ^ c[5] ^ c[6];
      s4 = c[3] ^ c[4] ^ c[5] ^ c[6];
      return {s4, s2, s1};
   endfunction

   function automatic logic [3:0] ref_dat(logic [6:0] c);
      logic [2:0] s;
      logic [6:0] f;
      s = ref_syn(c);
      f = c;
      if (s != 0) f[s-1] = ~f[s-1];
      return {f[6], f[5], f[4], f[2]};
   endfunction

   // drive one decode word and, in the same cycle, an unrelated encode nibble
   task automatic send(logic [6:0] code, logic [3:0] ed, string req);
      item_t it;
      @(posedge clk);
      #1;
      in_valid = 1'b1;
      rx_code  = code;
      enc_data = ed;
      it.data = ref_dat(code);
      it.syn  = ref_syn(code);
      it.due  = cyc + 1;
      it.req  = req;
      q.push_back(it);
      #0.5;
      chk(enc_code == ref_enc(ed), "R2", "encoder same cycle", enc_code, ref_enc(ed));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
         in_valid = 1'b0;
         rx_code  = 7'($urandom);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            chk(out_valid, "R7", "out_valid on due cycle", out_valid, 1);
            chk(data_out == it.data, it.req, "data_out", data_out, it.data);
            chk(syndrome == it.syn, it.req, "syndrome", syndrome, it.syn);
            chk(err_corrected == (it.syn != 0), "R9", "err_corrected",
                err_corrected, (it.syn != 0));
            last_d = data_out; last_s = syndrome; last_e = err_corrected;
            have_last = 1;
         end else begin
            if (out_valid) chk(0, "R8", "unexpected out_valid", 1, 0);
            if (have_last)
               chk(data_out == last_d && syndrome == last_s && err_corrected == last_e,
                   "R8", "held outputs", {data_out, syndrome, err_corrected},
                   {last_d, last_s, last_e});
         end
      end
   end

   task automatic finish_run();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst = 1'b0;
      @(negedge clk);
      chk({out_valid, data_out, syndrome, err_corrected} == 0, "R10", "reset state",
          {out_valid, data_out, syndrome, err_corrected}, 0);

      // R1/R2: encoder over all nibbles, combinational
      for (int d = 0; d < 16; d++) begin
         enc_data = 4'(d);
         #0.2;
         chk(enc_code == ref_enc(4'(d)), "R1", "encoder layout", enc_code, ref_enc(4'(d)));
      end

      // R3: fixed example
      enc_data = 4'b1101;
      #0.2;
      chk(enc_code == 7'b1100110, "R3", "example codeword", enc_code, 7'b1100110);
      send(7'b1100110 ^ 7'b0010000, 4'h0, "R3");
      idle(1);

      // R4: loopback, encoder output fed to decoder in the same cycle
      for (int d = 0; d < 16; d++) begin
         @(posedge clk);
         #1;
         enc_data = 4'(d);
         #0.2;
         rx_code  = enc_code;
         in_valid = 1'b1;
         begin
            item_t it;
            it.data = 4'(d); it.syn = 3'd0; it.due = cyc + 1; it.req = "R4";
            q.push_back(it);
         end
      end
      idle(2);

      // R5/R6: every single flip, back to back, unrelated encoder traffic
      for (int d = 0; d < 16; d++) begin
         for (int p = 1; p <= 7; p++) begin
            send(ref_enc(4'(d)) ^ (7'd1 << (p - 1)), 4'(15 - d),
                 (p == 1 || p == 2 || p == 4) ? "R6" : "R5");
         end
      end
      idle(4);

      // R11: double flips, mixed with gaps to exercise R8 hold
      for (int d = 0; d < 16; d += 3) begin
         for (int a = 1; a <= 7; a++) begin
            for (int b = a + 1; b <= 7; b += 2) begin
               send(ref_enc(4'(d)) ^ (7'd1 << (a - 1)) ^ (7'd1 << (b - 1)),
                    4'(d + a), "R11");
            end
            idle(2);
         end
      end
      idle(4);
      chk(q.size() == 0, "R7", "scoreboard drained", q.size(), 0);

      // R10: reset clears non-zero outputs
      send(ref_enc(4'hF) ^ 7'b1000000, 4'h3, "R5");
      idle(2);
      @(posedge clk);
      #1;
      rst = 1'b1;
      @(posedge clk);
      #1;
      @(negedge clk);
      chk({out_valid, data_out, syndrome, err_corrected} == 0, "R10", "reset clears",
          {out_valid, data_out, syndrome, err_corrected}, 0);
      finish_run();
   end
endmodule